// File: doc/BRIEF.md
# Deflection Crossbar Scheduler with Per-Input Park Slot

This block decides, every cycle, where each flit arriving at a bufferless router leaves. Each input presents at most one flit. The flit carries a wanted output port, a count of how often it has already been deflected, and a count of how often it has already been parked. The scheduler ranks competing flits by the sum of those two counts. The best flit for each output goes straight through. Every other flit is either parked for one cycle in a single-entry slot at its own input, or sent out of any output that is still free. No flit is ever dropped.

A parked flit comes back on the next cycle and competes in place of whatever arrives at that input. A `hold` output tells the upstream link that the input is busy with a parked flit, and any arrival offered during that cycle is not taken. All decisions are combinational from the presented flits, so results appear in the same cycle. Only the park slots are registered.

Top module: `defl_xbar_sched`

## Requirements
- R1: After a synchronous reset every `hold` bit is low. An input that presents nothing shows zero on `out_grant`, `out_loop`, `out_defl`, `out_port` and both count outputs.
- R2: For each output port, the requester with the largest key (deflect count plus park count) is passed. It gets `out_grant`=1, `out_port` equal to its wanted port (binary port index), `out_defl`=0 and `out_loop`=0, and both of its counts are unchanged.
- R3: When two requesters for the same port have equal keys, the one on the lower-numbered input wins.
- R4: A losing requester whose park count is below 2 is parked. It gets `out_loop`=1 and `out_grant`=0, and its park count is raised by one while its deflect count is unchanged.
- R5: A parked flit is presented on the next cycle, with its updated counts, in place of any arrival on that input. `hold` is high for exactly that cycle unless the flit is parked again, and an arrival offered while `hold` is high has no effect on the outputs.
- R6: A losing requester whose park count is 2 or more is deflected. It gets `out_grant`=1 and `out_defl`=1, its deflect count is raised by one, and its park count is unchanged.
- R7: Both counts saturate at 7. A deflected flit that arrives with deflect count 7 leaves with 7.
- R8: Every presented flit receives exactly one of a grant or a park, and no two granted inputs share an output port.
- R9: Deflected flits take outputs in ascending input order. Each one takes the lowest-numbered output not already used by a passed flit or by a deflected flit on a lower input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 4 | Arrival present, per input |
| in_dst | input | 4x2 | Wanted output port, per input |
| in_dfl | input | 4x3 | Arrival deflect count, per input |
| in_lpb | input | 4x3 | Arrival park count, per input |
| out_grant | output | 4 | Flit of this input leaves on `out_port` |
| out_port | output | 4x2 | Output port assigned, per input |
| out_defl | output | 4 | Flit was deflected |
| out_loop | output | 4 | Flit was parked in the input slot |
| out_dfl_cnt | output | 4x3 | Updated deflect count |
| out_lpb_cnt | output | 4x3 | Updated park count |
| hold | output | 4 | Input slot holds a parked flit this cycle |

## Verification
The sweep covers every pattern of present inputs and every assignment of wanted ports for four inputs. The counts vary with the pattern, so that ties, clear winners, parks and deflections all appear. Patterns where all inputs target one port separate the ranking and tie rule from the free-port fill order. Patterns with distinct targets show that uncontested flits always pass. After each pattern, the parked flits are drained over further cycles while junk arrivals are offered on the held inputs. This shows that replay takes precedence, that park counts grow, and that a flit is deflected once its park count reaches the limit. Directed cases pin down an equal-key tie and deflect-count saturation.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

    parameter int N_PORTS = 4;
    parameter int PORT_W  = $clog2(N_PORTS);
    parameter int CNT_W   = 3;
    parameter int KEY_W   = CNT_W + 1;
    parameter logic [CNT_W-1:0] CNT_MAX  = '1;
    parameter logic [CNT_W-1:0] LB_LIMIT = CNT_W'(2);

    typedef struct packed {
        logic              vld;
        logic [PORT_W-1:0] dst;
        logic [CNT_W-1:0]  dfl;
        logic [CNT_W-1:0]  lpb;
    } flit_req_t;

    typedef enum logic [1:0] {
        RES_IDLE,
        RES_PASS,
        RES_LOOP,
        RES_DEFL
    } res_e;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + CNT_W'(1);
    endfunction

    function automatic logic [KEY_W-1:0] prio_key(input flit_req_t r);
        return {1'b0, r.dfl} + {1'b0, r.lpb};
    endfunction

    // a outranks b: larger key, or equal key on a lower input index
    function automatic logic outranks(input flit_req_t a, input int ia,
                                      input flit_req_t b, input int ib);
        logic [KEY_W-1:0] ka;
        logic [KEY_W-1:0] kb;
        ka = prio_key(a);
        kb = prio_key(b);
        return (ka > kb) || ((ka == kb) && (ia < ib));
    endfunction

endpackage

// File: rtl/dfl_loop_slot.sv
module dfl_loop_slot
    import dfl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flit_req_t arr,
    input  logic      park,
    input  flit_req_t park_flit,
    output flit_req_t eff,
    output logic      busy
);

    flit_req_t stored_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            stored_q <= '0;
        end else begin
            // a presented flit is always resolved, so the slot only stays full when re-parked
            busy <= park;
            if (park) stored_q <= park_flit;
        end
    end

    always_comb begin
        if (busy) begin
            eff     = stored_q;
            eff.vld = 1'b1;
        end else begin
            eff = arr;
        end
    end

endmodule

// File: rtl/dfl_rank.sv
module dfl_rank
    import dfl_pkg::*;
(
    input  flit_req_t [N_PORTS-1:0] req,
    output logic      [N_PORTS-1:0] win
);

    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            win[i] = req[i].vld;
            for (int j = 0; j < N_PORTS; j++) begin
                if (j != i && req[j].vld && req[j].dst == req[i].dst &&
                    outranks(req[j], j, req[i], i))
                    win[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dfl_fill.sv
module dfl_fill
    import dfl_pkg::*;
(
    input  flit_req_t [N_PORTS-1:0]             req,
    input  logic      [N_PORTS-1:0]             win,
    output res_e      [N_PORTS-1:0]             res,
    output logic      [N_PORTS-1:0][PORT_W-1:0] port
);

    logic [N_PORTS-1:0] claimed;
    logic               got;

    always_comb begin
        claimed = '0;
        got     = 1'b0;
        for (int i = 0; i < N_PORTS; i++)
            if (win[i]) claimed[req[i].dst] = 1'b1;

        for (int i = 0; i < N_PORTS; i++) begin
            res[i]  = RES_IDLE;
            port[i] = '0;
            got     = 1'b0;
            if (req[i].vld) begin
                if (win[i]) begin
                    res[i]  = RES_PASS;
                    port[i] = req[i].dst;
                end else if (req[i].lpb < LB_LIMIT) begin
                    res[i] = RES_LOOP;
                end else begin
                    res[i] = RES_DEFL;
                    for (int o = 0; o < N_PORTS; o++) begin
                        if (!got && !claimed[o]) begin
                            port[i]    = PORT_W'(o);
                            claimed[o] = 1'b1;
                            got        = 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/defl_xbar_sched.sv
module defl_xbar_sched
    import dfl_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [N_PORTS-1:0]                   in_vld,
    input  logic [N_PORTS-1:0][PORT_W-1:0]       in_dst,
    input  logic [N_PORTS-1:0][CNT_W-1:0]        in_dfl,
    input  logic [N_PORTS-1:0][CNT_W-1:0]        in_lpb,
    output logic [N_PORTS-1:0]                   out_grant,
    output logic [N_PORTS-1:0][PORT_W-1:0]       out_port,
    output logic [N_PORTS-1:0]                   out_defl,
    output logic [N_PORTS-1:0]                   out_loop,
    output logic [N_PORTS-1:0][CNT_W-1:0]        out_dfl_cnt,
    output logic [N_PORTS-1:0][CNT_W-1:0]        out_lpb_cnt,
    output logic [N_PORTS-1:0]                   hold
);

    flit_req_t [N_PORTS-1:0]             arr;
    flit_req_t [N_PORTS-1:0]             eff;
    flit_req_t [N_PORTS-1:0]             park_flit;
    logic      [N_PORTS-1:0]             park;
    logic      [N_PORTS-1:0]             win;
    res_e      [N_PORTS-1:0]             res;
    logic      [N_PORTS-1:0][PORT_W-1:0] fill_port;
    logic      [N_PORTS-1:0][N_PORTS-1:0] claim;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_slot
        assign arr[g] = '{vld: in_vld[g], dst: in_dst[g], dfl: in_dfl[g], lpb: in_lpb[g]};

        dfl_loop_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .arr       (arr[g]),
            .park      (park[g]),
            .park_flit (park_flit[g]),
            .eff       (eff[g]),
            .busy      (hold[g])
        );
    end

    dfl_rank u_rank (
        .req (eff),
        .win (win)
    );

    dfl_fill u_fill (
        .req  (eff),
        .win  (win),
        .res  (res),
        .port (fill_port)
    );

    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            out_grant[i]   = 1'b0;
            out_defl[i]    = 1'b0;
            out_loop[i]    = 1'b0;
            out_port[i]    = '0;
            out_dfl_cnt[i] = '0;
            out_lpb_cnt[i] = '0;
            case (res[i])
                RES_PASS: begin
                    out_grant[i]   = 1'b1;
                    out_port[i]    = fill_port[i];
                    out_dfl_cnt[i] = eff[i].dfl;
                    out_lpb_cnt[i] = eff[i].lpb;
                end
                RES_DEFL: begin
                    out_grant[i]   = 1'b1;
                    out_defl[i]    = 1'b1;
                    out_port[i]    = fill_port[i];
                    out_dfl_cnt[i] = sat_inc(eff[i].dfl);
                    out_lpb_cnt[i] = eff[i].lpb;
                end
                RES_LOOP: begin
                    out_loop[i]    = 1'b1;
                    out_dfl_cnt[i] = eff[i].dfl;
                    out_lpb_cnt[i] = sat_inc(eff[i].lpb);
                end
                default: ;
            endcase
            park[i]      = out_loop[i];
            park_flit[i] = '{vld: 1'b1, dst: eff[i].dst, dfl: out_dfl_cnt[i], lpb: out_lpb_cnt[i]};
        end
    end

    always_comb begin
        for (int o = 0; o < N_PORTS; o++)
            for (int i = 0; i < N_PORTS; i++)
                claim[o][i] = out_grant[i] && (out_port[i] == PORT_W'(o));
    end

    for (genvar o = 0; o < N_PORTS; o++) begin : g_port_chk
        // R8
        port_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(claim[o]));
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_in_chk
        // R8
        one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
            eff[i].vld |-> (out_grant[i] ^ out_loop[i]));
        // R1
        idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !eff[i].vld |-> !(out_grant[i] || out_loop[i] || out_defl[i]));
        // R5
        park_then_hold_chk: assert property (@(posedge clk) disable iff (rst)
            out_loop[i] |=> hold[i]);
        // R5
        hold_release_chk: assert property (@(posedge clk) disable iff (rst)
            (hold[i] && !out_loop[i]) |=> !hold[i]);
        // R4
        park_limit_chk: assert property (@(posedge clk) disable iff (rst)
            out_loop[i] |-> (out_lpb_cnt[i] <= LB_LIMIT));
        // R6
        defl_granted_chk: assert property (@(posedge clk) disable iff (rst)
            out_defl[i] |-> (out_grant[i] && !out_loop[i]));
    end

endmodule

// File: tb/defl_xbar_sched_bench.sv
module defl_xbar_sched_bench;

    logic            clk = 1'b0;
    logic            rst;
    logic [3:0]      in_vld;
    logic [3:0][1:0] in_dst;
    logic [3:0][2:0] in_dfl;
    logic [3:0][2:0] in_lpb;
    logic [3:0]      out_grant;
    logic [3:0][1:0] out_port;
    logic [3:0]      out_defl;
    logic [3:0]      out_loop;
    logic [3:0][2:0] out_dfl_cnt;
    logic [3:0][2:0] out_lpb_cnt;
    logic [3:0]      hold;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    bit  m_busy [4];
    int  m_dst  [4];
    int  m_dfl  [4];
    int  m_lpb  [4];

    always #5 clk = ~clk;

    defl_xbar_sched u_defl_xbar_sched (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_dst(in_dst), .in_dfl(in_dfl), .in_lpb(in_lpb),
        .out_grant(out_grant), .out_port(out_port), .out_defl(out_defl),
        .out_loop(out_loop), .out_dfl_cnt(out_dfl_cnt), .out_lpb_cnt(out_lpb_cnt),
        .hold(hold)
    );

    task automatic chk(input string tag, input int i, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s input %0d: got %0d expected %0d", tag, i, act, exp);
        end
    endtask

    function automatic int sat7(input int v);
        return (v >= 7) ? 7 : v + 1;
    endfunction

    // one scheduling cycle against the arithmetic model
    task automatic step(input bit av[4], input int ad[4], input int adf[4], input int alp[4]);
        int ev[4], ed[4], ef[4], el[4];
        int xg[4], xp[4], xd[4], xl[4], xf[4], xb[4];
        bit win[4];
        bit used[4];
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk("R5 hold", i, int'(hold[i]), int'(m_busy[i]));
            in_vld[i] = av[i];
            in_dst[i] = 2'(ad[i]);
            in_dfl[i] = 3'(adf[i]);
            in_lpb[i] = 3'(alp[i]);
            if (m_busy[i]) begin
                ev[i] = 1; ed[i] = m_dst[i]; ef[i] = m_dfl[i]; el[i] = m_lpb[i];
            end else begin
                ev[i] = int'(av[i]); ed[i] = ad[i]; ef[i] = adf[i]; el[i] = alp[i];
            end
        end
        for (int i = 0; i < 4; i++) begin
            win[i] = (ev[i] != 0);
            for (int j = 0; j < 4; j++)
                if (j != i && ev[j] != 0 && ed[j] == ed[i] &&
                    ((ef[j] + el[j] > ef[i] + el[i]) ||
                     (ef[j] + el[j] == ef[i] + el[i] && j < i)))
                    win[i] = 0;
        end
        for (int o = 0; o < 4; o++) used[o] = 0;
        for (int i = 0; i < 4; i++) if (win[i]) used[ed[i]] = 1;
        for (int i = 0; i < 4; i++) begin
            xg[i] = 0; xp[i] = 0; xd[i] = 0; xl[i] = 0; xf[i] = 0; xb[i] = 0;
            if (ev[i] != 0) begin
                if (win[i]) begin
                    xg[i] = 1; xp[i] = ed[i]; xf[i] = ef[i]; xb[i] = el[i];
                end else if (el[i] < 2) begin
                    xl[i] = 1; xf[i] = ef[i]; xb[i] = sat7(el[i]);
                end else begin
                    xg[i] = 1; xd[i] = 1; xf[i] = sat7(ef[i]); xb[i] = el[i];
                    for (int o = 3; o >= 0; o--) if (!used[o]) xp[i] = o;
                    used[xp[i]] = 1;
                end
            end
        end
        #2;
        for (int i = 0; i < 4; i++) begin
            chk("R2 R3 R8 grant", i, int'(out_grant[i]), xg[i]);
            chk(xd[i] != 0 ? "R9 deflect port" : "R2 pass port", i, int'(out_port[i]), xp[i]);
            chk("R6 deflect flag", i, int'(out_defl[i]), xd[i]);
            chk("R4 park flag", i, int'(out_loop[i]), xl[i]);
            chk("R7 R6 deflect count", i, int'(out_dfl_cnt[i]), xf[i]);
            chk("R7 R4 park count", i, int'(out_lpb_cnt[i]), xb[i]);
        end
        for (int i = 0; i < 4; i++) begin
            m_busy[i] = (xl[i] != 0);
            if (xl[i] != 0) begin
                m_dst[i] = ed[i]; m_dfl[i] = xf[i]; m_lpb[i] = xb[i];
            end
        end
        @(posedge clk);
    endtask

    task automatic drain();
        bit av[4];
        int ad[4], adf[4], alp[4];
        bit any;
        any = 1;
        while (any) begin
            any = 0;
            for (int i = 0; i < 4; i++) begin
                any = any | m_busy[i];
                av[i] = m_busy[i];      // junk arrivals on held inputs, R5
                ad[i] = 3 - i; adf[i] = 6; alp[i] = 1;
            end
            if (any) step(av, ad, adf, alp);
        end
    endtask

    initial begin
        bit av[4];
        int ad[4], adf[4], alp[4];
        for (int i = 0; i < 4; i++) begin
            m_busy[i] = 0; m_dst[i] = 0; m_dfl[i] = 0; m_lpb[i] = 0;
        end
        rst = 1'b1; in_vld = '0; in_dst = '0; in_dfl = '0; in_lpb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        for (int i = 0; i < 4; i++) begin
            chk("R1 hold after reset", i, int'(hold[i]), 0);
            chk("R1 idle grant", i, int'(out_grant[i] | out_loop[i] | out_defl[i]), 0);
            chk("R1 idle counts", i, int'(out_dfl_cnt[i]) + int'(out_lpb_cnt[i]) + int'(out_port[i]), 0);
        end
        @(posedge clk);

        // R3: equal keys for port 1, input 0 beats input 2
        av = '{1, 0, 1, 0}; ad = '{1, 0, 1, 0}; adf = '{1, 0, 3, 0}; alp = '{2, 0, 0, 0};
        step(av, ad, adf, alp);
        drain();

        // R7: deflect count 7 stays 7 on deflection
        av = '{1, 1, 0, 0}; ad = '{0, 0, 0, 0}; adf = '{7, 7, 0, 0}; alp = '{3, 3, 0, 0};
        step(av, ad, adf, alp);
        drain();

        for (int p = 0; p < 4096; p++) begin
            for (int i = 0; i < 4; i++) begin
                av[i]  = p[i];
                ad[i]  = (p >> (4 + 2 * i)) & 3;
                adf[i] = ((p >> 3) + 3 * i) % 8;
                alp[i] = ((p >> 5) + i) % 4;
            end
            step(av, ad, adf, alp);
            drain();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule